// File: doc/BRIEF.md
# External Request Command Handler

This block receives commands from an external bus agent and carries them out against a small resource model on the processor side. The model holds one interrupt register and a small set of cache-line entries. Each entry has a two-bit coherence state and one data doubleword. A command arrives as a type code, an address, write data with byte enables, a state-modify enable and a replacement state. The block answers with a completion strobe and the response fields that belong to that command type: returned data, reported line state, a flag saying line data was returned, and an error flag. The receiver treats the error flag as a bus error.

The block handles one command at a time. `req_ready` shows when a command can be taken. A command is accepted on a rising clock edge where both `req_valid` and `req_ready` are high. Lookup commands (snoop and intervention) use one cycle to read the entry and a second cycle to report it. Every other command completes one cycle after it is accepted.

The address is split into two spaces. When bit ADDR_W-1 is 1, the address is in line space and the line index is the low IDX_W bits. When that bit is 0, the address is in register space, and the interrupt register sits at offset 0. Every command that targets a line takes its index from the low IDX_W bits.

Top module: `ext_req_handler`

## Requirements
- R1: After a synchronous reset (`rst_n` low), `req_ready` is 1 and `rsp_done` is 0. The interrupt register reads 0, every line state is invalid (00) and all line data is 0.
- R2: Read (type 000) completes one cycle after it is accepted.
  - In register space at offset 0, it returns the interrupt register zero-extended.
  - In line space, it returns the indexed line's data.
  - At any other register-space address, it returns 0 with `rsp_err` set.
- R3: Write (type 001) changes only the interrupt register. It writes at register-space offset 0, byte k taken from `req_wdata` when `req_be[k]` is 1, for the low INTR_W/8 bytes. At any other address, nothing changes and `rsp_err` is set.
- R4: Invalidate (type 010) sets the indexed line state to 00, keeps the line data, and completes one cycle after it is accepted.
- R5: Update (type 011) replaces every byte of the indexed line for which `req_be` is set. If the line was invalid, it becomes clean (01); any other state is kept. It completes one cycle after it is accepted.
- R6: Snoop (type 100) completes two cycles after it is accepted, and `req_ready` is 0 in between. It reports the line state as it was before the command (00 invalid, 01 clean, 10 shared, 11 dirty). If the line was valid and `req_mod_en` is 1, the state becomes `req_new_state`.
- R7: Intervention (type 101) has the same timing and state behaviour as snoop. Only when the reported state is dirty (11) does it set `rsp_data_ret` and return the line data on `rsp_data`. Otherwise `rsp_data` is 0.
- R8: Null (type 110) completes one cycle after it is accepted and changes nothing.
- R9: The reserved type 111 completes one cycle after it is accepted, sets `rsp_err`, and changes nothing.
- R10: `rsp_done` is a single-cycle pulse for each accepted command. While `rsp_done` is 0, `rsp_data`, `rsp_state`, `rsp_data_ret` and `rsp_err` are all 0.
- R11: A `req_valid` that arrives while `req_ready` is 0 is not accepted and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Command present |
| req_type | input | 3 | Command type code |
| req_addr | input | ADDR_W | Resource address or line index |
| req_wdata | input | DATA_W | Write or update data |
| req_be | input | DATA_W/8 | Byte enables for write or update |
| req_mod_en | input | 1 | Snoop/intervention may change state |
| req_new_state | input | 2 | Replacement line state |
| req_ready | output | 1 | Block can accept a command |
| rsp_done | output | 1 | Completion strobe |
| rsp_data | output | DATA_W | Returned data |
| rsp_state | output | 2 | Reported line state |
| rsp_data_ret | output | 1 | Line data returned by intervention |
| rsp_err | output | 1 | Bus error indication |

## Verification
A corrupted line state stays hidden until the next snoop or intervention on that line. That command reports the bad code two cycles after it is accepted, and it may wrongly set or clear `rsp_data_ret`. A wrongly merged data byte shows up on the first read of that line in line space, or on an intervention of a dirty line. A mistake in the interrupt register shows up on the next read at register offset 0. Random mixed traffic therefore follows every state-changing command with later lookups and reads against a bench model. Directed cases cover the first snoop after reset, a request held during a lookup, and reserved codes.

// File: rtl/ext_req_pkg.sv
// Package: shared command and line-state encodings for the external
// request handler. Assumes the 3-bit type code and 2-bit state code
// are fixed by the bus agent.
package ext_req_pkg;
    typedef enum logic [2:0] {
        OP_READ   = 3'b000,
        OP_WRITE  = 3'b001,
        OP_INVAL  = 3'b010,
        OP_UPDATE = 3'b011,
        OP_SNOOP  = 3'b100,
        OP_INTERV = 3'b101,
        OP_NULL   = 3'b110,
        OP_RSVD   = 3'b111
    } op_e;

    typedef enum logic [1:0] {
        LS_INVALID = 2'b00,
        LS_CLEAN   = 2'b01,
        LS_SHARED  = 2'b10,
        LS_DIRTY   = 2'b11
    } lstate_e;

    typedef enum logic {
        FSM_IDLE   = 1'b0,
        FSM_LOOKUP = 1'b1
    } fsm_e;
endpackage

// File: rtl/ext_req_decode.sv
// Module: combinational command decoder. It classifies the type code,
// splits the address into register or line space, and flags commands that
// must report a bus error. Assumes the address MSB selects line space.
module ext_req_decode
    import ext_req_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic [2:0]        req_type,
    input  logic [ADDR_W-1:0] req_addr,
    output op_e               dec_op,
    output logic [IDX_W-1:0]  dec_idx,
    output logic              dec_line_space,
    output logic              dec_intr_hit,
    output logic              dec_two_cycle,
    output logic              dec_err
);
    // address fields: space select, register offset test, line index
    always_comb begin
        dec_op         = op_e'(req_type);
        dec_line_space = req_addr[ADDR_W-1];
        dec_intr_hit   = !req_addr[ADDR_W-1] && (req_addr[ADDR_W-2:0] == '0);
        dec_idx        = req_addr[IDX_W-1:0];
    end

    // lookup commands take the two-cycle path
    always_comb begin
        dec_two_cycle = (dec_op == OP_SNOOP) || (dec_op == OP_INTERV);
    end

    // error classification per command type
    always_comb begin
        unique case (dec_op)
            OP_READ:  dec_err = !dec_line_space && !dec_intr_hit;
            OP_WRITE: dec_err = !dec_intr_hit;
            OP_RSVD:  dec_err = 1'b1;
            default:  dec_err = 1'b0;
        endcase
    end
endmodule

// File: rtl/ext_req_store.sv
// Module: resource model holding the interrupt register plus the state
// and data of each line. It has one read port, one line-data write port
// with byte enables, one state write port and one interrupt write port.
// Assumes the caller never writes data and state of different lines
// in conflict within one cycle.
module ext_req_store
    import ext_req_pkg::*;
#(
    parameter int NLINES = 8,
    parameter int DATA_W = 64,
    parameter int INTR_W = 32,
    localparam int IDX_W   = $clog2(NLINES),
    localparam int BE_W    = DATA_W / 8,
    localparam int INTR_BE = INTR_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              intr_we,
    input  logic [INTR_W-1:0] intr_wdata,
    input  logic [INTR_BE-1:0] intr_be,
    input  logic              line_we,
    input  logic [IDX_W-1:0]  line_widx,
    input  logic [DATA_W-1:0] line_wdata,
    input  logic [BE_W-1:0]   line_be,
    input  logic              st_we,
    input  logic [IDX_W-1:0]  st_widx,
    input  lstate_e           st_wval,
    input  logic [IDX_W-1:0]  rd_idx,
    output lstate_e           rd_state,
    output logic [DATA_W-1:0] rd_data,
    output logic [INTR_W-1:0] intr_q
);
    lstate_e           state_q [NLINES];
    logic [DATA_W-1:0] data_q  [NLINES];

    // interrupt register, byte-merged write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intr_q <= '0;
        end else if (intr_we) begin
            for (int b = 0; b < INTR_BE; b++) begin
                if (intr_be[b]) intr_q[b*8 +: 8] <= intr_wdata[b*8 +: 8];
            end
        end
    end

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        // per-line state register
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                state_q[g] <= LS_INVALID;
            end else if (st_we && (st_widx == IDX_W'(g))) begin
                state_q[g] <= st_wval;
            end
        end

        // per-line data register with byte enables
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[g] <= '0;
            end else if (line_we && (line_widx == IDX_W'(g))) begin
                for (int b = 0; b < BE_W; b++) begin
                    if (line_be[b]) data_q[g][b*8 +: 8] <= line_wdata[b*8 +: 8];
                end
            end
        end
    end

    // asynchronous read port
    always_comb begin
        rd_state = state_q[rd_idx];
        rd_data  = data_q[rd_idx];
    end

    AST_INTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !intr_we |=> $stable(intr_q)); // R3
endmodule

// File: rtl/ext_req_handler.sv
// Module: top of the external request handler. It accepts one command at
// a time, runs one-cycle commands straight away and sends snoop and
// intervention through a lookup cycle, then drives a registered response
// that is zero except in the completion cycle. Assumes the agent holds
// the command fields stable while req_valid is high.
module ext_req_handler
    import ext_req_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 64,
    parameter int INTR_W = 32,
    parameter int NLINES = 8,
    localparam int IDX_W   = $clog2(NLINES),
    localparam int BE_W    = DATA_W / 8,
    localparam int INTR_BE = INTR_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_type,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    input  logic              req_mod_en,
    input  logic [1:0]        req_new_state,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_data,
    output logic [1:0]        rsp_state,
    output logic              rsp_data_ret,
    output logic              rsp_err
);
    op_e              dec_op;
    logic [IDX_W-1:0] dec_idx;
    logic             dec_line_space, dec_intr_hit, dec_two_cycle, dec_err;

    fsm_e             fsm_q;
    op_e              lat_op;
    logic [IDX_W-1:0] lat_idx;
    logic             lat_mod;
    lstate_e          lat_nst;

    logic              accept;
    logic              intr_we, line_we, st_we;
    logic [IDX_W-1:0]  st_widx, rd_idx;
    lstate_e           st_wval, rd_state;
    logic [DATA_W-1:0] rd_data;
    logic [INTR_W-1:0] intr_q;

    ext_req_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) decode_i (
        .req_type       (req_type),
        .req_addr       (req_addr),
        .dec_op         (dec_op),
        .dec_idx        (dec_idx),
        .dec_line_space (dec_line_space),
        .dec_intr_hit   (dec_intr_hit),
        .dec_two_cycle  (dec_two_cycle),
        .dec_err        (dec_err)
    );

    ext_req_store #(.NLINES(NLINES), .DATA_W(DATA_W), .INTR_W(INTR_W)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .intr_we    (intr_we),
        .intr_wdata (req_wdata[INTR_W-1:0]),
        .intr_be    (req_be[INTR_BE-1:0]),
        .line_we    (line_we),
        .line_widx  (dec_idx),
        .line_wdata (req_wdata),
        .line_be    (req_be),
        .st_we      (st_we),
        .st_widx    (st_widx),
        .st_wval    (st_wval),
        .rd_idx     (rd_idx),
        .rd_state   (rd_state),
        .rd_data    (rd_data),
        .intr_q     (intr_q)
    );

    // acceptance handshake: only while idle
    always_comb begin
        req_ready = (fsm_q == FSM_IDLE);
        accept    = req_valid && req_ready;
    end

    // store port steering for accepted commands and the lookup cycle
    always_comb begin
        rd_idx  = (fsm_q == FSM_LOOKUP) ? lat_idx : dec_idx;
        intr_we = accept && (dec_op == OP_WRITE) && !dec_err;
        line_we = accept && (dec_op == OP_UPDATE);
        st_we   = 1'b0;
        st_widx = dec_idx;
        st_wval = LS_INVALID;
        if (fsm_q == FSM_LOOKUP) begin
            st_widx = lat_idx;
            st_wval = lat_nst;
            st_we   = lat_mod && (rd_state != LS_INVALID);
        end else if (accept && (dec_op == OP_INVAL)) begin
            st_we   = 1'b1;
        end else if (accept && (dec_op == OP_UPDATE) && (rd_state == LS_INVALID)) begin
            st_we   = 1'b1;
            st_wval = LS_CLEAN;
        end
    end

    // two-state sequencer for lookup commands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q <= FSM_IDLE;
        end else if (fsm_q == FSM_LOOKUP) begin
            fsm_q <= FSM_IDLE;
        end else if (accept && dec_two_cycle) begin
            fsm_q <= FSM_LOOKUP;
        end
    end

    // capture of the lookup command fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_op  <= OP_NULL;
            lat_idx <= '0;
            lat_mod <= 1'b0;
            lat_nst <= LS_INVALID;
        end else if (accept) begin
            lat_op  <= dec_op;
            lat_idx <= dec_idx;
            lat_mod <= req_mod_en;
            lat_nst <= lstate_e'(req_new_state);
        end
    end

    // registered response, zero outside the completion cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done     <= 1'b0;
            rsp_data     <= '0;
            rsp_state    <= 2'b00;
            rsp_data_ret <= 1'b0;
            rsp_err      <= 1'b0;
        end else begin
            rsp_done     <= 1'b0;
            rsp_data     <= '0;
            rsp_state    <= 2'b00;
            rsp_data_ret <= 1'b0;
            rsp_err      <= 1'b0;
            if (fsm_q == FSM_LOOKUP) begin
                rsp_done  <= 1'b1;
                rsp_state <= rd_state;
                if ((lat_op == OP_INTERV) && (rd_state == LS_DIRTY)) begin
                    rsp_data_ret <= 1'b1;
                    rsp_data     <= rd_data;
                end
            end else if (accept && !dec_two_cycle) begin
                rsp_done <= 1'b1;
                rsp_err  <= dec_err;
                if ((dec_op == OP_READ) && !dec_err) begin
                    rsp_data <= dec_line_space ? rd_data
                                               : {{(DATA_W-INTR_W){1'b0}}, intr_q};
                end
            end
        end
    end

    AST_LOOKUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec_two_cycle) |=> (!req_ready && !rsp_done)); // R6
    AST_LOOKUP_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q == FSM_LOOKUP) |=> (rsp_done && req_ready)); // R6
    AST_QUICK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !dec_two_cycle) |=> rsp_done); // R8
    AST_RET_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_data_ret |-> (rsp_state == 2'b11)); // R7
    AST_RSVD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (req_type == 3'b111)) |=> rsp_err); // R9
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_done |-> (rsp_data == '0 && rsp_state == 2'b00 && !rsp_data_ret && !rsp_err)); // R10
endmodule

// File: tb/ext_req_handler_tb_top.sv
module ext_req_handler_tb_top;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 64;
    localparam int INTR_W = 32;
    localparam int NLINES = 8;
    localparam int BE_W   = DATA_W / 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [2:0]        req_type = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [BE_W-1:0]   req_be = '0;
    logic              req_mod_en = 1'b0;
    logic [1:0]        req_new_state = '0;
    logic              req_ready, rsp_done, rsp_data_ret, rsp_err;
    logic [DATA_W-1:0] rsp_data;
    logic [1:0]        rsp_state;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [1:0]        m_state [NLINES];
    logic [DATA_W-1:0] m_data  [NLINES];
    logic [INTR_W-1:0] m_intr;

    always #10 clk = ~clk;

    ext_req_handler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INTR_W(INTR_W), .NLINES(NLINES)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_mod_en(req_mod_en), .req_new_state(req_new_state),
        .req_ready(req_ready), .rsp_done(rsp_done), .rsp_data(rsp_data),
        .rsp_state(rsp_state), .rsp_data_ret(rsp_data_ret), .rsp_err(rsp_err)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] ty);
        case (ty)
            3'd0: return "R2 read";
            3'd1: return "R3 write";
            3'd2: return "R4 invalidate";
            3'd3: return "R5 update";
            3'd4: return "R6 snoop";
            3'd5: return "R7 intervention";
            3'd6: return "R8 null";
            default: return "R9 reserved";
        endcase
    endfunction

    // response packed as {done, err, ret, state, data}
    function automatic logic [127:0] pack_rsp(input logic d, input logic e, input logic r,
                                              input logic [1:0] s, input logic [DATA_W-1:0] x);
        return 128'({d, e, r, s, x});
    endfunction

    // bench model: returns expected response and updates model state
    function automatic logic [127:0] model_step(input logic [2:0] ty, input logic [ADDR_W-1:0] ad,
                                                input logic [DATA_W-1:0] wd, input logic [BE_W-1:0] be,
                                                input logic md, input logic [1:0] ns);
        logic [2:0] ix;
        logic       line_sp, intr_hit, e, r;
        logic [1:0] s;
        logic [DATA_W-1:0] x;
        ix = ad[2:0];
        line_sp = ad[ADDR_W-1];
        intr_hit = !line_sp && (ad[ADDR_W-2:0] == '0);
        e = 1'b0; r = 1'b0; s = 2'b00; x = '0;
        case (ty)
            3'd0: begin
                if (line_sp) x = m_data[ix];
                else if (intr_hit) x = {32'h0, m_intr};
                else e = 1'b1;
            end
            3'd1: begin
                if (intr_hit) begin
                    for (int b = 0; b < INTR_W/8; b++)
                        if (be[b]) m_intr[b*8 +: 8] = wd[b*8 +: 8];
                end else e = 1'b1;
            end
            3'd2: m_state[ix] = 2'b00;
            3'd3: begin
                for (int b = 0; b < BE_W; b++)
                    if (be[b]) m_data[ix][b*8 +: 8] = wd[b*8 +: 8];
                if (m_state[ix] == 2'b00) m_state[ix] = 2'b01;
            end
            3'd4, 3'd5: begin
                s = m_state[ix];
                if (ty == 3'd5 && s == 2'b11) begin
                    r = 1'b1;
                    x = m_data[ix];
                end
                if (md && s != 2'b00) m_state[ix] = ns;
            end
            3'd6: ;
            default: e = 1'b1;
        endcase
        return pack_rsp(1'b1, e, r, s, x);
    endfunction

    function automatic logic [127:0] dut_rsp();
        return pack_rsp(rsp_done, rsp_err, rsp_data_ret, rsp_state, rsp_data);
    endfunction

    task automatic run_req(input logic [2:0] ty, input logic [ADDR_W-1:0] ad,
                           input logic [DATA_W-1:0] wd, input logic [BE_W-1:0] be,
                           input logic md, input logic [1:0] ns);
        logic [127:0] exp;
        string tg;
        tg = tag_of(ty);
        exp = model_step(ty, ad, wd, be, md, ns);
        @(negedge clk);
        chk("R10 quiet between commands", dut_rsp(), 128'h0);
        req_valid = 1'b1; req_type = ty; req_addr = ad; req_wdata = wd;
        req_be = be; req_mod_en = md; req_new_state = ns;
        @(negedge clk);
        req_valid = 1'b0;
        if (ty == 3'd4 || ty == 3'd5) begin
            chk({tg, " lookup cycle ready/done"}, 128'({req_ready, rsp_done}), 128'h0);
            @(negedge clk);
        end
        chk(tg, dut_rsp(), exp);
    endtask

    initial begin
        int wd_cycles = 0;
        while (wd_cycles < 150000 && !finished) begin
            @(posedge clk);
            wd_cycles++;
        end
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [2:0] ty;
        logic [ADDR_W-1:0] ad;
        void'($urandom(32'h5eed_c0de));
        for (int i = 0; i < NLINES; i++) begin
            m_state[i] = 2'b00;
            m_data[i]  = '0;
        end
        m_intr = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1 ready/done after reset", 128'({req_ready, rsp_done}), 128'h2);
        chk("R1 response zero after reset", dut_rsp(), 128'h0);
        run_req(3'd0, 8'h00, '0, '0, 1'b0, 2'b00);
        for (int i = 0; i < NLINES; i++) run_req(3'd4, ADDR_W'(8'h80 + i), '0, '0, 1'b1, 2'b11);
        run_req(3'd0, 8'h85, '0, '0, 1'b0, 2'b00);

        // directed corner cases
        run_req(3'd1, 8'h00, 64'hFFFF_FFFF_A1B2_C3D4, 8'b0000_0101, 1'b0, 2'b00);
        run_req(3'd0, 8'h00, '0, '0, 1'b0, 2'b00);
        run_req(3'd1, 8'h80, 64'h1234_5678_9ABC_DEF0, 8'hFF, 1'b0, 2'b00);
        run_req(3'd1, 8'h03, 64'h1234_5678_9ABC_DEF0, 8'hFF, 1'b0, 2'b00);
        run_req(3'd0, 8'h00, '0, '0, 1'b0, 2'b00);
        run_req(3'd0, 8'h07, '0, '0, 1'b0, 2'b00);
        run_req(3'd3, 8'h82, 64'h0011_2233_4455_6677, 8'b1100_0011, 1'b0, 2'b00);
        run_req(3'd0, 8'h82, '0, '0, 1'b0, 2'b00);
        run_req(3'd4, 8'h82, '0, '0, 1'b1, 2'b11);
        run_req(3'd5, 8'h82, '0, '0, 1'b1, 2'b10);
        run_req(3'd5, 8'h82, '0, '0, 1'b0, 2'b00);
        run_req(3'd2, 8'h82, '0, '0, 1'b0, 2'b00);
        run_req(3'd5, 8'h82, '0, '0, 1'b1, 2'b11);
        run_req(3'd0, 8'h82, '0, '0, 1'b0, 2'b00);
        run_req(3'd6, 8'h82, 64'hFFFF, 8'hFF, 1'b1, 2'b11);
        run_req(3'd7, 8'h00, 64'hFFFF, 8'hFF, 1'b1, 2'b11);
        run_req(3'd0, 8'h00, '0, '0, 1'b0, 2'b00);

        // R11: request held during the lookup cycle is ignored
        @(negedge clk);
        req_valid = 1'b1; req_type = 3'd4; req_addr = 8'h81; req_mod_en = 1'b0;
        void'(model_step(3'd4, 8'h81, '0, '0, 1'b0, 2'b00));
        @(negedge clk);
        req_type = 3'd1; req_addr = 8'h00; req_wdata = 64'h0; req_be = 8'hFF;
        chk("R11 ready low in lookup", 128'(req_ready), 128'h0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 lookup completes", 128'(rsp_done), 128'h1);
        run_req(3'd0, 8'h00, '0, '0, 1'b0, 2'b00);

        // constrained random mix
        for (int n = 0; n < 600; n++) begin
            ty = 3'($urandom % 8);
            case ($urandom % 4)
                0: ad = 8'h00;
                1: ad = {1'b0, 7'($urandom)};
                default: ad = {1'b1, 4'($urandom), 3'($urandom)};
            endcase
            run_req(ty, ad, {$urandom, $urandom}, 8'($urandom), 1'($urandom), 2'($urandom));
        end
        for (int i = 0; i < NLINES; i++) run_req(3'd5, ADDR_W'(8'h80 + i), '0, '0, 1'b0, 2'b00);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule